// File: doc/BRIEF.md
# Bridge Control Register File

This block is a bank of 28 word-wide control registers that a host reaches over a simple register bus: a byte address, a write strobe, write data and combinational read data. The words hold configuration, GPIO, interrupt-controller setup, mailbox, cache-control and timing values for the rest of a bridge. Software uses only aligned 32-bit accesses, and the word index is the byte offset divided by four.

Most words are plain storage with fixed reset defaults. Three behaviours go beyond storage. First, the general-configuration word at offset 0x04 raises a one-cycle system-reset request when a write moves its bit 2 from 0 to 1. Second, the words at 0x30 and 0x34 act as a set port and a clear port on an interrupt-enable mask. That mask can be read at 0x38 and is driven out as a 32-bit vector. Third, the word at 0x3C is read-only.

Top module: `bridge_ctl_regs`

## Requirements
- R1: Out of reset, offset 0x00 reads 0x00000C40, 0x04 reads 0x00001384, 0x08 reads 0x2BFF8010, 0x0C reads 0x255E0091, 0x10 reads 0x00006140, 0x1C and 0x20 read 0x000001FF, 0x68 reads 0x00000008 and 0x6C reads 0x10000000. Every other word reads zero, and the enable output is zero.
- R2: An aligned write to any plain storage word stores all 32 bits. This includes the mailbox words at 0x40, 0x44, 0x48 and 0x4C and every word other than 0x38 and 0x3C. The stored value reads back from the next cycle on.
- R3: The word read is selected by address bits [7:2]. Offsets 0x70 through 0xFC read zero, and writes to them change no word and no output.
- R4: An access whose address bits [1:0] are non-zero is invalid. A write of this kind changes nothing, and a read of this kind returns zero.
- R5: A write to 0x04 whose data has bit 2 set, while the stored bit 2 is 0, drives the reset-request output high for exactly the one cycle that follows the write edge. The new value is stored.
- R6: A write to 0x04 raises no reset request when the stored bit 2 is already 1 or when the written bit 2 is 0.
- R7: A write to 0x30 stores the data at 0x30 and ORs it into the enable mask.
- R8: A write to 0x34 stores the data at 0x34 and clears the enable-mask bits that are set in the data.
- R9: Offset 0x38 reads the enable mask, which equals the enable output. Writes to 0x38 and 0x3C are ignored, and 0x3C always reads zero.
- R10: The enable output changes only on the edge that takes a valid write to 0x30 or 0x34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| sys_rst_req_o | output | 1 | One-cycle system-reset request |
| int_en_o | output | 32 | Interrupt-enable mask |

## Verification
Read data is combinational from the address and the stored words. The bench therefore applies an address on the falling edge and compares rdata_o shortly after, before the next rising edge. A write takes effect on the rising edge that samples it. Its stored value and the new int_en_o are checked at the falling edge that follows. sys_rst_req_o is registered, so it is checked high at the falling edge right after the triggering write, and low one full cycle later. The reference model is updated at the same point as the write, so every comparison uses the state the design holds in that cycle.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  parameter int DATA_W    = 32;
  parameter int ADDR_W    = 8;
  parameter int NUM_WORDS = 28;
  localparam int IDX_W    = ADDR_W - 2;

  localparam int IDX_GEN  = 1;
  localparam int IDX_SET  = 12;
  localparam int IDX_CLR  = 13;
  localparam int IDX_EN   = 14;
  localparam int IDX_ISR  = 15;
  localparam int RST_BIT  = 2;

  function automatic logic [DATA_W-1:0] word_default(input int idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7, 8:    return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 rd_ok_o,
  output logic [NUM_WORDS-1:0] we_o
);
  logic aligned, in_range;

  assign idx_o    = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_range = (idx_o < IDX_W'(NUM_WORDS));
  assign rd_ok_o  = aligned && in_range;

  // read-only words never get a strobe
  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++) begin
      we_o[i] = wr_en_i && rd_ok_o && (idx_o == IDX_W'(i))
                && (i != IDX_EN) && (i != IDX_ISR);
    end
  end
endmodule

// File: rtl/bcr_word_bank.sv
module bcr_word_bank
  import bcr_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_WORDS-1:0]              we_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  words_o
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    if (g == IDX_EN || g == IDX_ISR) begin : g_ro
      assign words_o[g] = '0;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q <= word_default(g);
        else if (we_i[g]) q <= wdata_i;
      end
      assign words_o[g] = q;
    end
  end
endmodule

// File: rtl/bcr_int_enable.sv
module bcr_int_enable
  import bcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] en_o
);
  logic [DATA_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (set_we_i) en_q <= en_q | wdata_i;
    else if (clr_we_i) en_q <= en_q & ~wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/bcr_soft_reset.sv
module bcr_soft_reset (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_we_i,
  input  logic old_bit_i,
  input  logic new_bit_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= gen_we_i && !old_bit_i && new_bit_i;
  end

  assign req_o = req_q;
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
  import bcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sys_rst_req_o,
  output logic [DATA_W-1:0] int_en_o
);
  logic [IDX_W-1:0]                  idx;
  logic                              rd_ok;
  logic [NUM_WORDS-1:0]              we;
  logic [NUM_WORDS-1:0][DATA_W-1:0]  words;
  logic [DATA_W-1:0]                 en;

  bcr_decode u_decode (
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .idx_o   (idx),
    .rd_ok_o (rd_ok),
    .we_o    (we)
  );

  bcr_word_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wdata_i (wdata_i),
    .words_o (words)
  );

  bcr_int_enable u_inten (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (we[IDX_SET]),
    .clr_we_i (we[IDX_CLR]),
    .wdata_i  (wdata_i),
    .en_o     (en)
  );

  bcr_soft_reset u_srst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gen_we_i  (we[IDX_GEN]),
    .old_bit_i (words[IDX_GEN][RST_BIT]),
    .new_bit_i (wdata_i[RST_BIT]),
    .req_o     (sys_rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (idx == IDX_W'(i)) rdata_o = (i == IDX_EN) ? en : words[i];
      end
    end
  end

  assign int_en_o = en;
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
  import bcr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sys_rst_req_o,
  input logic [DATA_W-1:0] int_en_o
);
  logic set_wr, clr_wr, gen_wr;
  assign set_wr = wr_en_i && addr_i == ADDR_W'(IDX_SET * 4);
  assign clr_wr = wr_en_i && addr_i == ADDR_W'(IDX_CLR * 4);
  assign gen_wr = wr_en_i && addr_i == ADDR_W'(IDX_GEN * 4);

  // R7
  set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> int_en_o == ($past(int_en_o) | $past(wdata_i)));

  // R8
  clr_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> int_en_o == ($past(int_en_o) & ~$past(wdata_i)));

  // R10
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_wr || clr_wr) |=> $stable(int_en_o));

  // R5
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o);

  // R5
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |-> $past(gen_wr) && $past(wdata_i[RST_BIT]));

  // R9
  en_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(IDX_EN * 4)) |-> rdata_o == int_en_o);
endmodule

bind bridge_ctl_regs bcr_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wr_en_i       (wr_en_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .sys_rst_req_o (sys_rst_req_o),
  .int_en_o      (int_en_o)
);

// File: tb/sim_bridge_ctl_regs.sv
`timescale 1ns/1ps
module sim_bridge_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;
  logic [31:0] en;

  int total = 0;
  int bad = 0;
  logic [31:0] m [0:27];
  logic [31:0] m_en;

  always #4 clk = ~clk;

  bridge_ctl_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .sys_rst_req_o(req), .int_en_o(en)
  );

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0: return 32'hC40;       1: return 32'h1384;
      2: return 32'h2BFF8010;  3: return 32'h255E0091;
      4: return 32'h6140;      7: return 32'h1FF;
      8: return 32'h1FF;       26: return 32'h8;
      27: return 32'h10000000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a[1:0] != 0 || a[7:2] >= 28) return 32'h0;
    if (a[7:2] == 14) return m_en;
    return m[a[7:2]];
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(input string r, input logic [7:0] a);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1 chk(r, rdata, exp_read(a));
  endtask

  // drives a write, updates model, checks request pulse and enable
  task automatic wr(input string r, input logic [7:0] a, input logic [31:0] d);
    logic pulse;
    logic ok;
    int i;
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    ok = (a[1:0] == 0) && (a[7:2] < 28);
    i = a[7:2];
    pulse = ok && i == 1 && !m[1][2] && d[2];
    if (ok && i != 14 && i != 15) m[i] = d;
    if (ok && i == 12) m_en = m_en | d;
    if (ok && i == 13) m_en = m_en & ~d;
    @(negedge clk);
    wr_en = 1'b0;
    chk({r, " req"}, {31'b0, req}, {31'b0, pulse});
    chk({r, " en"}, en, m_en);
    @(negedge clk);
    chk({r, " req drop"}, {31'b0, req}, 32'h0);
  endtask

  initial begin
    logic [7:0] a;
    logic [31:0] d;
    for (int i = 0; i < 28; i++) m[i] = dflt(i);
    m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    for (int i = 0; i < 28; i++) rd("R1", 8'(i * 4));
    chk("R1 en", en, 32'h0);
    chk("R1 req", {31'b0, req}, 32'h0);
    // R2 mailboxes and a config word
    wr("R2", 8'h40, 32'hDEADBEEF); wr("R2", 8'h4C, 32'h01234567);
    wr("R2", 8'h08, 32'hA5A5A5A5);
    rd("R2", 8'h40); rd("R2", 8'h4C); rd("R2", 8'h08);
    // R3 out of range
    wr("R3", 8'h70, 32'hFFFFFFFF); wr("R3", 8'hFC, 32'h12345678);
    rd("R3", 8'h70); rd("R3", 8'hFC); rd("R3", 8'h00);
    // R4 unaligned
    wr("R4", 8'h41, 32'h0); wr("R4", 8'h32, 32'hFFFF);
    rd("R4", 8'h41); rd("R4", 8'h40); rd("R4", 8'h43);
    // R5 / R6: default bit2 of 0x04 is 1
    wr("R6", 8'h04, 32'h1384);
    wr("R6", 8'h04, 32'h0);
    wr("R6", 8'h04, 32'h0);
    wr("R5", 8'h04, 32'h4);
    rd("R5", 8'h04);
    wr("R6", 8'h04, 32'hFFFF);
    // R7 R8 R9 R10
    wr("R7", 8'h30, 32'h0000_00F0); rd("R7", 8'h30);
    wr("R7", 8'h30, 32'h8000_0001);
    wr("R8", 8'h34, 32'h0000_0030); rd("R8", 8'h34);
    wr("R9", 8'h38, 32'hFFFFFFFF); wr("R9", 8'h3C, 32'hFFFFFFFF);
    rd("R9", 8'h38); rd("R9", 8'h3C);
    wr("R10", 8'h50, 32'hFFFFFFFF);
    // random mix
    void'($urandom(32'd2024));
    for (int k = 0; k < 400; k++) begin
      a = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      if ($urandom_range(0, 2) == 0) a = 8'(4 * $urandom_range(0, 15));
      d = $urandom();
      if ($urandom_range(0, 1) == 0) wr("R10 rnd", a, d);
      else rd("R2 rnd", a);
    end
    for (int i = 0; i < 32; i++) rd("R3 sweep", 8'(i * 4 + 128));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule